// File: doc/BRIEF.md
# External Bus Hand-Over Controller

This block lets another bus master take over the processor's external memory bus. The other master raises a request. The controller synchronises the request and waits for any external access the core already has in flight. It then floats the processor's pad drivers and, one cycle later, grants the bus. Nothing else is connected to this block. It tells the core when to stall and when a deferred external access may go out.

A mode input selects how the core reacts while another master holds the bus. In stop mode the core is halted for the whole time the bus is given away. In run-on mode the core keeps running from internal memory and stalls only when it asks for an external access. That access is remembered and released as soon as the bus comes back. When the other master drops its request, the grant falls first. The drivers come back and the stall ends one cycle after that.

All signals are active high except `rst_n`. `drv_en` = 1 means the address, data, memory-select and read/write strobe drivers are driving; `drv_en` = 0 means they are in high impedance.

Top module: `bus_handover_ctrl`

## Requirements
- R1: `bus_req` passes through a two-flop synchroniser. It is recognised no earlier than the second rising edge after it goes high; until then all outputs keep their idle values.
- R2: In the cycle the request is recognised, `drv_en` falls to 0. It stays 0 for as long as `bus_grant` is 1.
- R3: `bus_grant` rises in the cycle after recognition, never in the recognition cycle itself.
- R4: With `go_mode` = 0, `core_halt` is 1 for every cycle that `bus_grant` is 1 and for the single return cycle that follows.
- R5: With `go_mode` = 1, `core_halt` stays 0 while the bus is granted until `ext_req` is raised. From that cycle on it stays 1 until the bus is owned again.
- R6: While `acc_busy` = 1, a synchronised request is not recognised: `drv_en` stays 1 and no grant is given. Recognition happens in the first cycle with `acc_busy` = 0.
- R7: After `bus_req` falls, `bus_grant` drops on the third rising edge. `drv_en` returns to 1 and `core_halt` to 0 one cycle after `bus_grant` drops.
- R8: An `ext_req` raised while the bus is not owned is kept pending. `ext_go` pulses for exactly one cycle, in the first cycle the bus is owned again.
- R9: While the bus is owned and no request is being recognised, `ext_req` gives `ext_go` = 1 in the same cycle, with `core_halt` = 0.
- R10: After reset the bus is owned: `bus_grant` = 0, `core_halt` = 0, `drv_en` = 1, `ext_go` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_req | input | 1 | Request from the other bus master, asynchronous |
| go_mode | input | 1 | 1 = core keeps running while the bus is granted; 0 = core stops |
| ext_req | input | 1 | Core needs an external memory access this cycle |
| acc_busy | input | 1 | An external access of the core is still in progress |
| bus_grant | output | 1 | Bus granted to the other master |
| core_halt | output | 1 | Stall request to the core |
| drv_en | output | 1 | 1 = pad drivers drive, 0 = high impedance |
| ext_go | output | 1 | Core's external access may proceed this cycle |

## Verification
The hardest case to reach from the ports is an external access deferred in run-on mode. The core must ask for memory while the bus is held elsewhere, and that request must then be released exactly once, in the first owned cycle after the return cycle. The stimulus holds a grant in run-on mode, pulses `ext_req` for one cycle mid-grant and then drops the request. It checks the stall through the return cycle and the single `ext_go` pulse after it. A second case keeps `acc_busy` high past synchronisation, so the bench can show that recognition waits for the in-flight access.

// File: rtl/bgc_pkg.sv
// Shared types for the bus hand-over controller.
// Assumes: one clock domain for everything except the raw bus request.
package bgc_pkg;
    typedef enum logic [1:0] {
        ST_OWN     = 2'd0,   // processor owns the external bus
        ST_GRANTED = 2'd1,   // other master holds the bus
        ST_RETURN  = 2'd2    // grant dropped, drivers still floating
    } bus_st_e;
endpackage

// File: rtl/bgc_req_sync.sv
// Synchroniser chain for the asynchronous bus request.
// Assumes STAGES >= 1; two stages are the intended setting.
module bgc_req_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single-flop capture.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= async_in;
            end
        end else begin : g_multi
            // Purpose: shift the request through the flop chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/bgc_grant_fsm.sv
// Hand-over state machine: recognises the synchronised request once no
// external access is in flight, floats the drivers, grants one cycle later,
// and walks back through a single return cycle when the request ends.
// Assumes req_sync is already in the clk domain.
module bgc_grant_fsm
    import bgc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    req_sync,
    input  logic    acc_busy,
    output bus_st_e state,
    output logic    recog,
    output logic    own_bus,
    output logic    bus_grant,
    output logic    drv_en
);
    bus_st_e state_q, state_d;

    // Purpose: recognition needs an owned bus and no access in flight.
    always_comb begin
        recog = (state_q == ST_OWN) && req_sync && !acc_busy;
    end

    // Purpose: next-state selection.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OWN:     if (recog)     state_d = ST_GRANTED;
            ST_GRANTED: if (!req_sync) state_d = ST_RETURN;
            ST_RETURN:                 state_d = ST_OWN;
            default:                   state_d = ST_OWN;
        endcase
    end

    // Purpose: state register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OWN;
        else        state_q <= state_d;
    end

    // Purpose: derive port-level controls from state.
    always_comb begin
        own_bus   = (state_q == ST_OWN) && !recog;
        bus_grant = (state_q == ST_GRANTED);
        drv_en    = own_bus;
        state     = state_q;
    end

    // R3: grant rises only one cycle after a recognition
    a_r3_grant_after_recog: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_grant) |-> $past(recog));
    // R6: an access in flight keeps the bus owned
    a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OWN && acc_busy) |=> (state_q == ST_OWN));
    // R7: exactly one return cycle after the grant drops
    a_r7_single_return: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_grant) |=> (state_q == ST_OWN));
endmodule

// File: rtl/bgc_access_track.sv
// Core-side stall logic: halts the core while the bus is away (stop mode)
// or only once it asks for external memory (run-on mode), and keeps a
// deferred access pending until the bus is owned again.
// Assumes ext_req is a request for the current cycle from the core.
module bgc_access_track
    import bgc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    go_mode,
    input  logic    ext_req,
    input  logic    own_bus,
    input  bus_st_e state,
    output logic    core_halt,
    output logic    ext_go
);
    logic pending_q;

    // Purpose: issue and stall decisions for this cycle.
    always_comb begin
        ext_go    = own_bus && (ext_req || pending_q);
        core_halt = (!go_mode && state != ST_OWN) ||
                    (!own_bus && (pending_q || ext_req));
    end

    // Purpose: remember an access refused while the bus is away.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pending_q <= 1'b0;
        else if (ext_go)             pending_q <= 1'b0;
        else if (ext_req && !own_bus) pending_q <= 1'b1;
    end

    // R8: a deferred access is not dropped while the bus is away
    a_r8_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_q && !own_bus) |=> pending_q);
    // R8: issue consumes the pending access
    a_r8_issue_once: assert property (@(posedge clk) disable iff (!rst_n)
        ext_go |=> !pending_q);
    // R5: run-on mode does not stall without an external request
    a_r5_run_on: assert property (@(posedge clk) disable iff (!rst_n)
        (go_mode && !pending_q && !ext_req) |-> !core_halt);
endmodule

// File: rtl/bus_handover_ctrl.sv
// Top of the bus hand-over controller: synchroniser, grant sequencing and
// core stall tracking.
// Assumes bus_req may change at any time; all other inputs are synchronous.
module bus_handover_ctrl
    import bgc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    input  logic go_mode,
    input  logic ext_req,
    input  logic acc_busy,
    output logic bus_grant,
    output logic core_halt,
    output logic drv_en,
    output logic ext_go
);
    logic    req_sync;
    logic    recog;
    logic    own_bus;
    bus_st_e state;

    bgc_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (bus_req),
        .sync_out (req_sync)
    );

    bgc_grant_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_sync  (req_sync),
        .acc_busy  (acc_busy),
        .state     (state),
        .recog     (recog),
        .own_bus   (own_bus),
        .bus_grant (bus_grant),
        .drv_en    (drv_en)
    );

    bgc_access_track u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_mode   (go_mode),
        .ext_req   (ext_req),
        .own_bus   (own_bus),
        .state     (state),
        .core_halt (core_halt),
        .ext_go    (ext_go)
    );

    // R2: drivers float whenever the bus is granted
    a_r2_float_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        bus_grant |-> !drv_en);
    // R4: stop mode halts the core while granted
    a_r4_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_grant && !go_mode) |-> core_halt);
    // R8: no access goes out while the drivers float
    a_r8_no_issue_floating: assert property (@(posedge clk) disable iff (!rst_n)
        ext_go |-> drv_en);
endmodule

// File: tb/sim_bus_handover_ctrl.sv
module sim_bus_handover_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0, go_mode = 1'b0, ext_req = 1'b0, acc_busy = 1'b0;
    logic bus_grant, core_halt, drv_en, ext_go;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic  g, h, d, x;
        string tag;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    bus_handover_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .go_mode(go_mode),
        .ext_req(ext_req), .acc_busy(acc_busy), .bus_grant(bus_grant),
        .core_halt(core_halt), .drv_en(drv_en), .ext_go(ext_go)
    );

    // Driver: apply one cycle of inputs and queue the outputs expected in it.
    task automatic drive(input logic rq, input logic gm, input logic er,
                         input logic bz, input logic eg, input logic eh,
                         input logic ed, input logic ex, input string tag);
        exp_t e;
        @(negedge clk);
        bus_req = rq; go_mode = gm; ext_req = er; acc_busy = bz;
        e.g = eg; e.h = eh; e.d = ed; e.x = ex; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare each queued expectation mid-cycle.
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if ({bus_grant, core_halt, drv_en, ext_go} !== {e.g, e.h, e.d, e.x}) begin
                errors++;
                $display("FAIL %s: got grant/halt/drv/go=%b%b%b%b expected %b%b%b%b at %0t",
                         e.tag, bus_grant, core_halt, drv_en, ext_go,
                         e.g, e.h, e.d, e.x, $time);
            end
        end
    end

    // Return sequence from an active grant: R7 timing, halt per mode.
    task automatic release_seq(input logic gm, input logic hgrant,
                               input logic hret, input logic xend);
        drive(0, gm, 0, 0, 1, hgrant, 0, 0, "R7");
        drive(0, gm, 0, 0, 1, hgrant, 0, 0, "R7");
        drive(0, gm, 0, 0, 1, hgrant, 0, 0, "R7");
        drive(0, gm, 0, 0, 0, hret,   0, 0, "R7");
        drive(0, gm, 0, 0, 0, 0,      1, xend, "R7");
        drive(0, gm, 0, 0, 0, 0,      1, 0, "R8");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R10");
        // R9: direct access while owned, no repeat afterwards
        drive(0, 0, 1, 0, 0, 0, 1, 1, "R9");
        drive(0, 0, 0, 0, 0, 0, 1, 0, "R9");
        // Stop mode grant: R1, R2, R3, R4, then R7
        drive(1, 0, 0, 0, 0, 0, 1, 0, "R1");
        drive(1, 0, 0, 0, 0, 0, 1, 0, "R1");
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R2");
        drive(1, 0, 0, 0, 1, 1, 0, 0, "R3");
        drive(1, 0, 0, 0, 1, 1, 0, 0, "R4");
        release_seq(0, 1, 1, 0);
        // R6: in-flight access delays recognition
        drive(1, 0, 0, 1, 0, 0, 1, 0, "R6");
        drive(1, 0, 0, 1, 0, 0, 1, 0, "R6");
        drive(1, 0, 0, 1, 0, 0, 1, 0, "R6");
        drive(1, 0, 0, 1, 0, 0, 1, 0, "R6");
        drive(1, 0, 0, 0, 0, 0, 0, 0, "R6");
        drive(1, 0, 0, 0, 1, 1, 0, 0, "R3");
        release_seq(0, 1, 1, 0);
        // R5 and R8: run-on mode with a deferred access
        drive(1, 1, 0, 0, 0, 0, 1, 0, "R1");
        drive(1, 1, 0, 0, 0, 0, 1, 0, "R1");
        drive(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        drive(1, 1, 0, 0, 1, 0, 0, 0, "R5");
        drive(1, 1, 0, 0, 1, 0, 0, 0, "R5");
        drive(1, 1, 1, 0, 1, 1, 0, 0, "R5");
        drive(1, 1, 0, 0, 1, 1, 0, 0, "R8");
        release_seq(1, 1, 1, 1);
        // R5: run-on mode without an access never stalls
        drive(1, 1, 0, 0, 0, 0, 1, 0, "R5");
        drive(1, 1, 0, 0, 0, 0, 1, 0, "R5");
        drive(1, 1, 0, 0, 0, 0, 0, 0, "R2");
        drive(1, 1, 0, 0, 1, 0, 0, 0, "R5");
        release_seq(1, 0, 0, 0);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run is reported as a failed check.
    initial begin
        #(5 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule